// File: doc/BRIEF.md
# Indirect Flash Access Controller

This controller lets a host or debug register port reach a byte-wide nonvolatile memory through three windows: a control byte, an address (split into a low and a high byte) and a data byte. The host never drives the memory directly. Instead, touching the data window with a write or a read starts a memory operation, and the mode fields in the control byte pick which one. A write can be held, programmed at the current address, or used as a key to erase a page or the whole user area. A read can return the held byte or start a fetch. A separate status byte reports whether an operation is in flight and whether a fetched byte is still waiting to be read.

Register selects are: 0 control, 1 address low byte, 2 address high byte, 3 data, 4 status (reads only; unused selects read as zero). Control bit 7 selects the 128-byte scratch sector, bits 6:4 hold the write mode and bits 3:0 hold the read mode. Status bit 0 is busy and bit 1 is data-valid. On the memory side the controller issues a one-cycle `mem_req` with an operation code: 0 fetch, 1 program, 2 page erase, 3 mass erase. It holds the operation, address, sector and data stable until the memory returns a one-cycle `mem_done`.

Top module: `nvm_indirect_port`

## Requirements
- R1: After reset the control, address, data and status registers read 0x00 and no memory request is issued.
- R2: With write mode 000, or any write mode from 011 to 111, a data write only replaces the held data byte and issues no request.
- R3: With write mode 001, a data write issues a program request (op 1) carrying the written byte and the current address, and the address register reads one higher once `mem_done` returns.
- R4: With write mode 010, a data write of 0xA5 issues a page erase (op 2) whose address is the current address rounded down to a 512-byte page boundary. Any other written value issues no request. The address register is unchanged in either case.
- R5: In the main sector, an erase-mode key write while the address is 0x7DFE or 0x7DFF issues a mass erase (op 3) with address 0, which wipes the user area below 0x7E00.
- R6: With control bit 7 set, every request asserts `mem_space`. Its address is the low 7 bits of the address register, zero-extended. An erase always becomes a page erase at address 0 that covers the whole scratch sector.
- R7: With read mode 0001, a data read while idle issues a fetch (op 0). On `mem_done` the fetched byte replaces the data register and status bit 1 sets.
- R8: Status bit 0 is set from the request until `mem_done`. While it is set, data writes, address writes and fetch triggers are ignored, and no second request is issued.
- R9: With read mode 0010, a data read issues a fetch only when idle and status bit 1 is clear. Any data read clears status bit 1.
- R10: With read mode 0000, or any read mode from 0011 to 1111, a data read returns the held byte and issues no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on the data select) |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the current select |
| mem_req | output | 1 | One-cycle memory operation request |
| mem_op | output | 2 | Operation code: 0 fetch, 1 program, 2 page erase, 3 mass erase |
| mem_space | output | 1 | 1 selects the scratch sector |
| mem_addr | output | 16 | Memory byte address, held while busy |
| mem_wdata | output | 8 | Byte to program, held while busy |
| mem_done | input | 1 | One-cycle completion from the memory |
| mem_rdata | input | 8 | Fetched byte, valid with mem_done |

## Verification
On every cycle, the assertions check the following:
- busy stays up until completion;
- no request starts while one is outstanding;
- the memory address stays stable for the duration of an operation;
- each program completion advances the address by one;
- any erase request carries the 0xA5 key;
- mass erase is never aimed at the scratch sector;
- a finished fetch leaves the valid flag set.

Some behaviour only the bench scenarios can show:
- that a request carries the right page base, the scratch address folding and the magic-address detection;
- that reserved mode codes stay silent and non-key values are refused;
- that the single-byte read mode skips exactly one fetch after a consumed byte.

// File: rtl/nvm_ifc_pkg.sv
package nvm_ifc_pkg;

    typedef enum logic [1:0] {
        OP_FETCH = 2'd0,
        OP_PROG  = 2'd1,
        OP_PAGE  = 2'd2,
        OP_MASS  = 2'd3
    } nvm_op_e;

    localparam logic [2:0] SEL_CTRL    = 3'd0;
    localparam logic [2:0] SEL_ADDR_LO = 3'd1;
    localparam logic [2:0] SEL_ADDR_HI = 3'd2;
    localparam logic [2:0] SEL_DATA    = 3'd3;
    localparam logic [2:0] SEL_STATUS  = 3'd4;

    localparam logic [2:0] WM_HOLD  = 3'b000;
    localparam logic [2:0] WM_PROG  = 3'b001;
    localparam logic [2:0] WM_ERASE = 3'b010;

    localparam logic [3:0] RM_BLOCK  = 4'b0001;
    localparam logic [3:0] RM_SINGLE = 4'b0010;

endpackage

// File: rtl/nvm_trigger_decode.sv
module nvm_trigger_decode
    import nvm_ifc_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DW        = 8,
    parameter int USER_TOP  = 32'h7E00,
    parameter int ERASE_KEY = 8'hA5
) (
    input  logic          data_wr,
    input  logic          data_rd,
    input  logic          busy,
    input  logic          valid,
    input  logic          scratch,
    input  logic [2:0]    wmode,
    input  logic [3:0]    rmode,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          start,
    output nvm_op_e       op
);
    localparam logic [AW-1:0] MAGIC_A = AW'(USER_TOP - 2);
    localparam logic [AW-1:0] MAGIC_B = AW'(USER_TOP - 1);
    localparam logic [DW-1:0] KEY     = DW'(ERASE_KEY);

    logic magic_hit;
    assign magic_hit = !scratch && (addr == MAGIC_A || addr == MAGIC_B);

    always_comb begin
        start = 1'b0;
        op    = OP_FETCH;
        if (data_wr && !busy) begin
            case (wmode)
                WM_PROG: begin
                    start = 1'b1;
                    op    = OP_PROG;
                end
                WM_ERASE: begin
                    if (wdata == KEY) begin
                        start = 1'b1;
                        op    = magic_hit ? OP_MASS : OP_PAGE;
                    end
                end
                default: start = 1'b0;
            endcase
        end else if (data_rd && !busy) begin
            case (rmode)
                RM_BLOCK:  start = 1'b1;
                RM_SINGLE: start = !valid;
                default:   start = 1'b0;
            endcase
            op = OP_FETCH;
        end
    end
endmodule

// File: rtl/nvm_addr_map.sv
module nvm_addr_map
    import nvm_ifc_pkg::*;
#(
    parameter int AW         = 16,
    parameter int SCR_AW     = 7,
    parameter int PAGE_BYTES = 512
) (
    input  logic          scratch,
    input  nvm_op_e       op,
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] phys
);
    localparam logic [AW-1:0] PAGE_MASK = ~AW'(PAGE_BYTES - 1);

    always_comb begin
        if (scratch) begin
            if (op == OP_PAGE || op == OP_MASS) phys = '0;
            else                                phys = {{(AW-SCR_AW){1'b0}}, addr[SCR_AW-1:0]};
        end else begin
            case (op)
                OP_PAGE: phys = addr & PAGE_MASK;
                OP_MASS: phys = '0;
                default: phys = addr;
            endcase
        end
    end
endmodule

// File: rtl/nvm_indirect_port.sv
module nvm_indirect_port
    import nvm_ifc_pkg::*;
#(
    parameter int AW         = 16,
    parameter int DW         = 8,
    parameter int SCR_AW     = 7,
    parameter int PAGE_BYTES = 512,
    parameter int USER_TOP   = 32'h7E00,
    parameter int ERASE_KEY  = 8'hA5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [2:0]    reg_sel,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          mem_req,
    output logic [1:0]    mem_op,
    output logic          mem_space,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_done,
    input  logic [DW-1:0] mem_rdata
);
    localparam int HI_W = AW - DW;

    typedef struct packed {
        logic [DW-1:0] ctrl;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          busy;
        logic          valid;
        logic          req;
        nvm_op_e       op;
        logic [AW-1:0] maddr;
        logic          space;
        logic [DW-1:0] mwdata;
    } st_t;

    st_t st_d, st_q;

    logic          scratch_sel;
    logic [2:0]    wmode;
    logic [3:0]    rmode;
    logic          data_wr, data_rd;
    logic          start;
    nvm_op_e       start_op;
    logic [AW-1:0] start_phys;

    assign scratch_sel = st_q.ctrl[7];
    assign wmode       = st_q.ctrl[6:4];
    assign rmode       = st_q.ctrl[3:0];
    assign data_wr     = reg_wr && reg_sel == SEL_DATA;
    assign data_rd     = reg_rd && !reg_wr && reg_sel == SEL_DATA;

    nvm_trigger_decode #(
        .AW(AW), .DW(DW), .USER_TOP(USER_TOP), .ERASE_KEY(ERASE_KEY)
    ) u_decode (
        .data_wr (data_wr),
        .data_rd (data_rd),
        .busy    (st_q.busy),
        .valid   (st_q.valid),
        .scratch (scratch_sel),
        .wmode   (wmode),
        .rmode   (rmode),
        .addr    (st_q.addr),
        .wdata   (reg_wdata),
        .start   (start),
        .op      (start_op)
    );

    nvm_addr_map #(
        .AW(AW), .SCR_AW(SCR_AW), .PAGE_BYTES(PAGE_BYTES)
    ) u_map (
        .scratch (scratch_sel),
        .op      (start_op),
        .addr    (st_q.addr),
        .phys    (start_phys)
    );

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        if (reg_wr) begin
            case (reg_sel)
                SEL_CTRL:    st_d.ctrl = reg_wdata;
                SEL_ADDR_LO: if (!st_q.busy) st_d.addr[DW-1:0] = reg_wdata;
                SEL_ADDR_HI: if (!st_q.busy) st_d.addr[AW-1:DW] = reg_wdata[HI_W-1:0];
                SEL_DATA:    if (!st_q.busy) st_d.data = reg_wdata;
                default:     st_d.ctrl = st_q.ctrl;
            endcase
        end
        if (data_rd) st_d.valid = 1'b0;
        if (start) begin
            st_d.req    = 1'b1;
            st_d.busy   = 1'b1;
            st_d.op     = start_op;
            st_d.maddr  = start_phys;
            st_d.space  = scratch_sel;
            st_d.mwdata = reg_wdata;
        end
        if (mem_done && st_q.busy) begin
            st_d.busy = 1'b0;
            if (st_q.op == OP_PROG) st_d.addr = st_q.addr + AW'(1);
            if (st_q.op == OP_FETCH) begin
                st_d.data  = mem_rdata;
                st_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (reg_sel)
            SEL_CTRL:    reg_rdata = st_q.ctrl;
            SEL_ADDR_LO: reg_rdata = st_q.addr[DW-1:0];
            SEL_ADDR_HI: reg_rdata = DW'(st_q.addr[AW-1:DW]);
            SEL_DATA:    reg_rdata = st_q.data;
            SEL_STATUS:  reg_rdata = DW'({st_q.valid, st_q.busy});
            default:     reg_rdata = '0;
        endcase
    end

    assign mem_req   = st_q.req;
    assign mem_op    = st_q.op;
    assign mem_space = st_q.space;
    assign mem_addr  = st_q.maddr;
    assign mem_wdata = st_q.mwdata;

    // R8: busy persists until the memory reports completion
    a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !mem_done) |=> st_q.busy);

    // R8: no fresh request while one is outstanding
    a_r8_no_req_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !mem_req) |=> !mem_req);

    // R3: operation address is held for the memory during the operation
    a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !mem_done) |=> $stable(mem_addr));

    // R3: program completion advances the address by one
    a_r3_addr_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_done && st_q.busy && st_q.op == OP_PROG) |=> st_q.addr == $past(st_q.addr) + AW'(1));

    // R4: every erase request was unlocked by the key byte
    a_r4_erase_keyed: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && (st_q.op == OP_PAGE || st_q.op == OP_MASS)) |-> mem_wdata == DW'(ERASE_KEY));

    // R5: whole-area erase never targets the scratch sector
    a_r5_mass_main_only: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && st_q.op == OP_MASS) |-> !mem_space);

    // R7: a finished fetch leaves unread data flagged
    a_r7_valid_on_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_done && st_q.busy && st_q.op == OP_FETCH) |=> st_q.valid);
endmodule

// File: tb/nvm_indirect_port_test.sv
module nvm_indirect_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic        mem_req, mem_space, mem_done;
    logic [1:0]  mem_op;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;

    int n_checks = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    nvm_indirect_port uut (
        .clk, .rst_n, .reg_wr, .reg_rd, .reg_sel, .reg_wdata, .reg_rdata,
        .mem_req, .mem_op, .mem_space, .mem_addr, .mem_wdata,
        .mem_done, .mem_rdata
    );

    // memory model: completes 3-4 cycles after a request
    int        lat = 0;
    int        req_cnt = 0;
    logic [1:0]  last_op = 0;
    logic [15:0] last_addr = 0;
    logic        last_sp = 0;
    logic [7:0]  last_wd = 0;
    initial mem_done = 1'b0;
    assign mem_rdata = mem_addr[7:0] ^ 8'h5A;

    always @(posedge clk) begin
        if (mem_req) begin
            lat       <= 3;
            req_cnt   <= req_cnt + 1;
            last_op   <= mem_op;
            last_addr <= mem_addr;
            last_sp   <= mem_space;
            last_wd   <= mem_wdata;
        end else if (lat != 0) begin
            lat <= lat - 1;
        end
        mem_done <= (lat == 1) && !mem_req;
    end

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] sel, input logic [7:0] val);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] sel, output logic [7:0] val);
        @(negedge clk);
        reg_sel = sel; reg_rd = (sel == 3'd3);
        #1 val = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic peek(input logic [2:0] sel, output logic [7:0] val);
        @(negedge clk);
        reg_sel = sel;
        #1 val = reg_rdata;
    endtask

    task automatic wait_idle();
        repeat (10) @(negedge clk);
    endtask

    typedef struct packed {
        logic [7:0]  ctrl;
        logic [15:0] addr;
        logic [7:0]  wd;
        logic        req;
        logic [1:0]  op;
        logic [15:0] eaddr;
        logic        sp;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        {8'h00, 16'h0123, 8'h3C, 1'b0, 2'd0, 16'h0000, 1'b0},  // R2 hold
        {8'h10, 16'h0123, 8'h3C, 1'b1, 2'd1, 16'h0123, 1'b0},  // R3 program
        {8'h20, 16'h0345, 8'hA5, 1'b1, 2'd2, 16'h0200, 1'b0},  // R4 page erase
        {8'h20, 16'h0345, 8'hA4, 1'b0, 2'd0, 16'h0000, 1'b0},  // R4 wrong key
        {8'h20, 16'h7DFE, 8'hA5, 1'b1, 2'd3, 16'h0000, 1'b0},  // R5 mass
        {8'h20, 16'h7DFF, 8'hA5, 1'b1, 2'd3, 16'h0000, 1'b0},  // R5 mass
        {8'h20, 16'h7DFD, 8'hA5, 1'b1, 2'd2, 16'h7C00, 1'b0},  // R5 neighbour is page
        {8'h30, 16'h0400, 8'h77, 1'b0, 2'd0, 16'h0000, 1'b0},  // R2 reserved
        {8'h90, 16'h01F5, 8'h11, 1'b1, 2'd1, 16'h0075, 1'b1},  // R6 scratch program
        {8'hA0, 16'h7DFE, 8'hA5, 1'b1, 2'd2, 16'h0000, 1'b1},  // R6 scratch erase
        {8'h70, 16'h0500, 8'h99, 1'b0, 2'd0, 16'h0000, 1'b0}   // R2 reserved
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v, lo, hi;
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        peek(3'd0, v); check("R1 ctrl", v, 8'h00);
        peek(3'd1, v); check("R1 addr lo", v, 8'h00);
        peek(3'd2, v); check("R1 addr hi", v, 8'h00);
        peek(3'd3, v); check("R1 data", v, 8'h00);
        peek(3'd4, v); check("R1 status", v, 8'h00);
        check("R1 no request", req_cnt, 0);

        for (int i = 0; i < NV; i++) begin
            vec_t t = VECS[i];
            base = req_cnt;
            reg_write(3'd0, t.ctrl);
            reg_write(3'd1, t.addr[7:0]);
            reg_write(3'd2, t.addr[15:8]);
            reg_write(3'd3, t.wd);
            wait_idle();
            check($sformatf("vector %0d request count", i), req_cnt - base, int'(t.req));
            if (t.req) begin
                check($sformatf("vector %0d op", i), last_op, t.op);
                check($sformatf("vector %0d address", i), last_addr, t.eaddr);
                check($sformatf("vector %0d space", i), last_sp, t.sp);
            end
            peek(3'd3, v); check($sformatf("vector %0d data held", i), v, t.wd);
            peek(3'd1, lo); peek(3'd2, hi);
            check($sformatf("vector %0d address reg", i), {hi, lo},
                  (t.req && t.op == 2'd1) ? t.addr + 16'd1 : t.addr);
        end

        // R8 writes ignored while busy
        reg_write(3'd0, 8'h10);
        reg_write(3'd1, 8'h00);
        reg_write(3'd2, 8'h02);
        base = req_cnt;
        reg_write(3'd3, 8'h11);
        peek(3'd4, v); check("R8 busy flag", v & 8'h01, 8'h01);
        reg_write(3'd3, 8'h22);
        reg_write(3'd1, 8'h80);
        wait_idle();
        check("R8 single request", req_cnt - base, 1);
        check("R8 programmed byte", last_wd, 8'h11);
        peek(3'd3, v); check("R8 data unchanged", v, 8'h11);
        peek(3'd1, v); check("R8 addr lo advanced only", v, 8'h01);
        peek(3'd4, v); check("R8 busy cleared", v, 8'h00);

        // R7 block read mode
        reg_write(3'd0, 8'h01);
        reg_write(3'd1, 8'h42);
        reg_write(3'd2, 8'h00);
        base = req_cnt;
        reg_read(3'd3, v);
        reg_read(3'd3, v);  // R8: read while busy, no second fetch
        wait_idle();
        check("R7 fetch issued", req_cnt - base, 1);
        check("R7 fetch op", last_op, 0);
        check("R7 fetch address", last_addr, 16'h0042);
        peek(3'd4, v); check("R7 valid set", v, 8'h02);
        peek(3'd3, v); check("R7 fetched byte", v, 8'h42 ^ 8'h5A);

        // R9 single read mode: valid set, read consumes without fetch
        reg_write(3'd0, 8'h02);
        base = req_cnt;
        reg_read(3'd3, v);
        wait_idle();
        check("R9 no fetch while unread", req_cnt - base, 0);
        check("R9 returned byte", v, 8'h42 ^ 8'h5A);
        peek(3'd4, v); check("R9 valid cleared", v, 8'h00);
        reg_read(3'd3, v);
        wait_idle();
        check("R9 fetch after consume", req_cnt - base, 1);
        peek(3'd4, v); check("R9 valid again", v, 8'h02);

        // R10 plain and reserved read modes
        reg_write(3'd0, 8'h00);
        base = req_cnt;
        reg_read(3'd3, v);
        wait_idle();
        check("R10 plain mode no fetch", req_cnt - base, 0);
        check("R10 plain mode data", v, 8'h42 ^ 8'h5A);
        reg_write(3'd0, 8'h03);
        reg_read(3'd3, v);
        reg_write(3'd0, 8'h0F);
        reg_read(3'd3, v);
        wait_idle();
        check("R10 reserved modes no fetch", req_cnt - base, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule